// File: doc/BRIEF.md
# Endpoint Receive Staging Buffer

This block sits between the receive path of a bulk-OUT USB endpoint and a RAM-backed FIFO. Payload bytes from the endpoint are caught in a two-entry staging buffer. While there is room they are written on into the FIFO, one byte per cycle. When the endpoint signals that a transaction finished normally, the block flushes what it still holds. It then raises a one-cycle transfer-complete pulse.

If the FIFO reports no free space at that moment, the transaction is not held up. The leftover one or two bytes stay parked in the staging buffer, and the completion pulse is withheld. A read-request flag is set and an interrupt is raised. Software frees at least two bytes of FIFO space, reads the 8-bit status register, and then writes zero to the flag. That write restarts the drain. Once the parked bytes have reached the FIFO, the completion pulse is issued.

Top module: `ep_rx_stage`

## Requirements
- R1: After `rst_n` is held low, `reg_rdata` reads 0x00, `irq` is low, `rx_ready` is high, and `fifo_wr` and `xfer_done` are low.
- R2: Accepted bytes (`rx_valid && rx_ready` at a clock edge) appear on `fifo_wdata` in arrival order. Each byte is written with one `fifo_wr` cycle, at most one per cycle. While receiving, a byte is written whenever one is held and `fifo_free` is nonzero.
- R3: The staging buffer holds at most 2 bytes. `rx_ready` is low while it holds 2 bytes, and also at any time after `rx_done` until the transaction is finished.
- R4: When `rx_done` is sampled and `fifo_free` stays nonzero, the held bytes are written out. Then `xfer_done` is high for exactly one cycle, and the read-request flag stays 0.
- R5: If, after `rx_done`, the block still holds data while `fifo_free` is 0, it sets the read-request flag to 1. It then makes no FIFO write, gives no `xfer_done` pulse and accepts no byte until the flag is cleared.
- R6: The status register reads `{7'b0, flag}`: bit 0 is the read-request flag and bits 7..1 always read 0. Writing 1s to bits 7..1 has no effect.
- R7: A write with bit 0 = 0 clears the flag only if a read (`reg_rd`) has returned the flag as 1 since the last clear. Such a write with no prior read is ignored, and a write with bit 0 = 1 is ignored. A successful clear re-arms the read requirement.
- R8: After a clear, no parked byte leaves until `fifo_free >= 2`. From then on, all parked bytes are written one per cycle, even if `fifo_free` drops. The cycle after the last write, `xfer_done` pulses once.
- R9: `irq` is high exactly when the flag is 1 and `irq_en` is high. It falls right after the clock edge at which the clearing write is taken.
- R10: A one-cycle `soft_rst` empties the staging buffer and clears the flag, so the register reads 0x00. `irq` goes low and `rx_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| soft_rst | input | 1 | Synchronous function-level reset, active high |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | DATA_W | Receive byte |
| rx_ready | output | 1 | Block can accept a byte this cycle |
| rx_done | input | 1 | Transaction completed normally |
| fifo_free | input | FREE_W | Free byte count reported by the RAM FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | Byte written to the FIFO |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | REG_W | Status register write data |
| reg_rdata | output | REG_W | Status register read data |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Read-request interrupt |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions check several rules on every cycle:
- a parked flag blocks FIFO writes, byte intake and the completion pulse;
- the flag rises only when the FIFO reported no room while data was held;
- it falls only after a zero-write or a function reset;
- no write is issued from an empty buffer;
- the completion pulse lasts a single cycle.

Byte ordering across many transactions can only be shown by the bench's scenarios. The same holds for the read-before-clear qualifier, the two-byte threshold with its latch once the drain has started, and the discarding of parked data by the function reset.

// File: rtl/ep_rx_stage_pkg.sv
// Shared types for the endpoint receive staging buffer.
package ep_rx_stage_pkg;

    // Phases of the drain controller.
    typedef enum logic [1:0] {
        ST_RECV  = 2'd0,  // accepting bytes, streaming to the FIFO
        ST_FLUSH = 2'd1,  // transaction ended, emptying the buffer
        ST_PARK  = 2'd2,  // FIFO was full, bytes parked, flag raised
        ST_DRAIN = 2'd3   // software cleared the flag, moving parked bytes
    } stage_state_e;

endpackage

// File: rtl/ep_stage_buf.sv
// Small circular staging buffer.
// Holds up to DEPTH bytes in arrival order. Push and pop may happen in the
// same cycle. Assumes the caller never pushes when full or pops when empty.
module ep_stage_buf #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CW-1:0]     count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Store an incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and occupancy; reset or function reset empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Oldest byte is always presented.
    assign dout = mem[rd_ptr];

endmodule

// File: rtl/ep_drain_ctrl.sv
// Drain controller.
// Decides when the oldest staged byte moves to the FIFO, when the transaction
// is reported complete, and when bytes must be parked because the FIFO is full.
// Assumes rx_done follows (or coincides with) the last accepted byte.
module ep_drain_ctrl
    import ep_rx_stage_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int FREE_W = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rx_done,
    input  logic [CW-1:0]     count,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              clr_ok,
    output logic              pop,
    output logic              park_set,
    output logic              recv_en,
    output logic              done_pulse
);

    localparam logic [FREE_W-1:0] RESTART_MIN = FREE_W'(DEPTH);

    stage_state_e state_q, state_d;
    logic         go_q, go_d;
    logic         done_q, done_d;
    logic         has_data;
    logic         room;

    assign has_data = (count != '0);
    assign room     = (fifo_free != '0);

    // Next-state, pop, and park decisions for the current phase.
    always_comb begin
        state_d  = state_q;
        go_d     = 1'b0;
        done_d   = 1'b0;
        pop      = 1'b0;
        park_set = 1'b0;
        case (state_q)
            ST_RECV: begin
                pop = has_data && room;
                if (rx_done) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (!has_data) begin
                    done_d  = 1'b1;
                    state_d = ST_RECV;
                end else if (!room) begin
                    park_set = 1'b1;
                    state_d  = ST_PARK;
                end else begin
                    pop = 1'b1;
                end
            end
            ST_PARK: begin
                if (clr_ok) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                go_d = go_q || (fifo_free >= RESTART_MIN);
                pop  = has_data && go_d;
                if (go_q && !has_data) begin
                    done_d  = 1'b1;
                    go_d    = 1'b0;
                    state_d = ST_RECV;
                end
            end
            default: state_d = ST_RECV;
        endcase
    end

    // Phase, drain-started latch and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= ST_RECV;
            go_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
            done_q  <= done_d;
        end
    end

    assign recv_en    = (state_q == ST_RECV);
    assign done_pulse = done_q;

endmodule

// File: rtl/ep_status_reg.sv
// Read-request status register.
// Holds the read-request flag, the read-seen qualifier for the clear write,
// read data formatting and the interrupt. Upper bits read 0 and ignore writes.
module ep_status_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             park_set,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             wbit0,
    input  logic             irq_en,
    output logic             flag,
    output logic             clr_ok,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);

    logic flag_q;
    logic seen_q;

    // A zero written to bit 0 clears only a flag that was read as 1 first.
    assign clr_ok = reg_wr && !wbit0 && seen_q && flag_q;

    // Flag and read-seen qualifier update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (park_set) begin
            flag_q <= 1'b1;
        end else if (clr_ok) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (reg_rd && flag_q) begin
            seen_q <= 1'b1;
        end
    end

    assign flag  = flag_q;
    assign rdata = {{(REG_W-1){1'b0}}, flag_q};
    assign irq   = flag_q && irq_en;

endmodule

// File: rtl/ep_rx_stage.sv
// Endpoint receive staging buffer, top level.
// Stages received bytes, streams them to a RAM FIFO, parks them with a
// read-request flag when the FIFO is full at transaction end, and restarts
// the drain after software clears the flag. Assumes fifo_free is the FIFO's
// current free byte count and that FIFO writes land at the next clock edge.
module ep_rx_stage #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8,
    parameter int FREE_W = 8,
    parameter int REG_W  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              rx_done,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              irq_en,
    output logic              irq,
    output logic              xfer_done
);

    logic [CW-1:0] buf_count;
    logic          push;
    logic          pop;
    logic          park_set;
    logic          recv_en;
    logic          clr_ok;
    logic          flag_q;
    logic          unused_wbits;

    // Bits above bit 0 of a register write carry no function.
    assign unused_wbits = ^reg_wdata[REG_W-1:1];

    assign rx_ready = recv_en && (buf_count < CW'(DEPTH));
    assign push     = rx_valid && rx_ready;
    assign fifo_wr  = pop;

    ep_stage_buf #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) buf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .push  (push),
        .din   (rx_data),
        .pop   (pop),
        .dout  (fifo_wdata),
        .count (buf_count)
    );

    ep_drain_ctrl #(
        .DEPTH  (DEPTH),
        .FREE_W (FREE_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .rx_done    (rx_done),
        .count      (buf_count),
        .fifo_free  (fifo_free),
        .clr_ok     (clr_ok),
        .pop        (pop),
        .park_set   (park_set),
        .recv_en    (recv_en),
        .done_pulse (xfer_done)
    );

    ep_status_reg #(
        .REG_W (REG_W)
    ) sreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .park_set (park_set),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .wbit0    (reg_wdata[0]),
        .irq_en   (irq_en),
        .flag     (flag_q),
        .clr_ok   (clr_ok),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

endmodule

// File: rtl/ep_rx_stage_chk.sv
// Protocol checker for ep_rx_stage, bound to every instance of the top module.
// Observes ports plus the staged-byte count and the read-request flag.
module ep_rx_stage_chk #(
    parameter int DEPTH  = 2,
    parameter int FREE_W = 8,
    parameter int REG_W  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              rx_ready,
    input logic [FREE_W-1:0] fifo_free,
    input logic              fifo_wr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              xfer_done,
    input logic [CW-1:0]     count,
    input logic              flag
);

    // R5: a raised flag blocks writes, intake and completion.
    a_r5_parked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (!fifo_wr && !rx_ready && !xfer_done));

    // R5: the flag rises only after the FIFO showed no room while data was held.
    a_r5_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(fifo_free) == '0 && count != '0));

    // R7: the flag falls only after a zero-write to bit 0 or a function reset.
    a_r7_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(soft_rst) || $past(reg_wr && !reg_wdata[0])));

    // R2: no FIFO write while the staging buffer is empty.
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (count != '0));

    // R4: the completion pulse lasts one cycle.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

endmodule

bind ep_rx_stage ep_rx_stage_chk #(
    .DEPTH  (DEPTH),
    .FREE_W (FREE_W),
    .REG_W  (REG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .rx_ready  (rx_ready),
    .fifo_free (fifo_free),
    .fifo_wr   (fifo_wr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .xfer_done (xfer_done),
    .count     (buf_count),
    .flag      (flag_q)
);

// File: tb/ep_rx_stage_tb_top.sv
`timescale 1ns/1ps
module ep_rx_stage_tb_top;

    localparam int DATA_W = 8;
    localparam int FREE_W = 8;
    localparam int REG_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              soft_rst = 1'b0;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_ready;
    logic              rx_done = 1'b0;
    logic [FREE_W-1:0] fifo_free = '0;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_wdata;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq_en = 1'b0;
    logic              irq;
    logic              xfer_done;

    int n_chk = 0;
    int n_err = 0;
    int done_cnt = 0;
    int wr_cnt = 0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_e;

    always #2.5 clk = ~clk;

    ep_rx_stage dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .rx_done    (rx_done),
        .fifo_free  (fifo_free),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_en     (irq_en),
        .irq        (irq),
        .xfer_done  (xfer_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected parking outcome of a transaction.
    function automatic bit exp_park(input int nbytes, input int free);
        return (nbytes > 0) && (free == 0);
    endfunction

    // Expected status register value for a given flag state.
    function automatic int exp_reg(input bit flag);
        return flag ? 32'h01 : 32'h00;
    endfunction

    // Monitor FIFO writes (R2 order) and completion pulses, away from the edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (fifo_wr) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "write with nothing expected", fifo_wdata, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(fifo_wdata == mon_e, "R2", "fifo byte order", fifo_wdata, mon_e);
                end
            end
            if (xfer_done) begin
                done_cnt++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        exp_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic end_tx();
        @(negedge clk);
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic rd_reg(output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int d0;
        int w0;
        void'($urandom(32'd20240611));

        // R1: reset state
        tick(4);
        #1;
        check(reg_rdata == 8'h00, "R1", "reset rdata", reg_rdata, 0);
        check(irq == 1'b0, "R1", "reset irq", irq, 0);
        check(rx_ready == 1'b1, "R1", "reset rx_ready", rx_ready, 1);
        check(fifo_wr == 1'b0 && xfer_done == 1'b0, "R1", "reset strobes",
              {fifo_wr, xfer_done}, 0);
        @(negedge clk);
        rst_n     = 1'b1;
        irq_en    = 1'b1;
        fifo_free = 8'd200;

        // R2/R4: normal streaming transaction
        d0 = done_cnt;
        for (int i = 0; i < 4; i++) send(8'h10 + 8'(i));
        end_tx();
        tick(4);
        #1;
        check(done_cnt == d0 + 1, "R4", "one completion pulse", done_cnt - d0, 1);
        check(exp_q.size() == 0, "R2", "all bytes written", exp_q.size(), 0);
        check(reg_rdata == 8'h00, "R4", "flag stays clear", reg_rdata, 0);

        // R3: buffer limit when the FIFO is full
        fifo_free = '0;
        w0 = wr_cnt;
        d0 = done_cnt;
        send(8'hA1);
        send(8'hA2);
        tick(2);
        #1;
        check(rx_ready == 1'b0, "R3", "ready low at 2 held bytes", rx_ready, 0);
        check(wr_cnt == w0, "R3", "no writes while full", wr_cnt - w0, 0);

        // R5/R6/R9: completion with a full FIFO parks the bytes
        end_tx();
        tick(3);
        #1;
        check(reg_rdata == 8'h01, "R6", "status reads flag only", reg_rdata, 1);
        check(irq == 1'b1, "R9", "irq with flag and enable", irq, 1);
        check(done_cnt == d0, "R5", "no completion while parked", done_cnt - d0, 0);
        check(rx_ready == 1'b0, "R5", "no intake while parked", rx_ready, 0);
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        check(irq == 1'b0, "R9", "irq masked by enable", irq, 0);
        @(negedge clk);
        irq_en = 1'b1;

        // R7: clear without a prior read is ignored
        wr_reg(8'h00);
        #1;
        check(reg_rdata == 8'h01, "R7", "clear without read ignored", reg_rdata, 1);
        rd_reg(v);
        check(v == 8'h01, "R6", "read value", v, 1);
        wr_reg(8'hFF);
        #1;
        check(reg_rdata == 8'h01, "R6", "write of ones no effect", reg_rdata, 1);

        // R7/R9: valid clear; R8: hold below two free bytes
        fifo_free = 8'd1;
        wr_reg(8'hFE);
        #1;
        check(reg_rdata == 8'h00, "R7", "flag cleared", reg_rdata, 0);
        check(irq == 1'b0, "R9", "irq drops with clear", irq, 0);
        w0 = wr_cnt;
        tick(5);
        #1;
        check(wr_cnt == w0, "R8", "no drain below 2 free", wr_cnt - w0, 0);
        check(done_cnt == d0, "R8", "no completion before drain", done_cnt - d0, 0);
        @(negedge clk);
        fifo_free = 8'd2;
        @(negedge clk);
        fifo_free = 8'd1;
        tick(4);
        #1;
        check(wr_cnt == w0 + 2, "R8", "both bytes drained once started", wr_cnt - w0, 2);
        check(done_cnt == d0 + 1, "R8", "completion after drain", done_cnt - d0, 1);
        check(rx_ready == 1'b1, "R8", "intake resumes", rx_ready, 1);

        // R10: function reset while parked
        fifo_free = '0;
        send(8'h5C);
        end_tx();
        tick(3);
        #1;
        check(reg_rdata == 8'h01, "R5", "parked before function reset", reg_rdata, 1);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        exp_q.delete();
        #1;
        check(reg_rdata == 8'h00, "R10", "function reset clears reg", reg_rdata, 0);
        check(irq == 1'b0, "R10", "function reset clears irq", irq, 0);
        check(rx_ready == 1'b1, "R10", "function reset empties buffer", rx_ready, 1);
        fifo_free = 8'd50;
        w0 = wr_cnt;
        send(8'h77);
        tick(3);
        #1;
        check(wr_cnt == w0 + 1, "R10", "only new byte written", wr_cnt - w0, 1);

        // Random transactions: R2, R4, R5, R7, R8
        for (int t = 0; t < 60; t++) begin
            int n;
            int fr;
            bit pk;
            fr = (($urandom % 3) == 0) ? 0 : 1 + int'($urandom % 255);
            n  = (fr == 0) ? 1 + int'($urandom % 2) : int'($urandom % 6);
            pk = exp_park(n, fr);
            fifo_free = FREE_W'(fr);
            d0 = done_cnt;
            for (int k = 0; k < n; k++) send(8'($urandom));
            end_tx();
            tick(4);
            #1;
            check(reg_rdata == 8'(exp_reg(pk)), pk ? "R5" : "R4", "random flag",
                  reg_rdata, exp_reg(pk));
            check(done_cnt == d0 + (pk ? 0 : 1), pk ? "R5" : "R4", "random completion",
                  done_cnt - d0, pk ? 0 : 1);
            if (pk) begin
                rd_reg(v);
                fifo_free = FREE_W'(2 + ($urandom % 10));
                wr_reg(8'h00);
                tick(5);
                #1;
                check(reg_rdata == 8'h00, "R7", "random clear", reg_rdata, 0);
                check(done_cnt == d0 + 1, "R8", "random drain completion",
                      done_cnt - d0, 1);
            end
            check(exp_q.size() == 0, "R2", "random all bytes written", exp_q.size(), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule